// File: doc/BRIEF.md
# Two-Wire Serial Byte-Memory Slave

This block is the slave side of a small non-volatile-style byte store reached over a two-wire bus: one clock line driven by the master and one shared open-drain data line. A fast system clock samples both lines through synchronizers. The sampled values are used to find the bus start and stop events and the clock edges. The store holds 128 bytes, and the array is built from plain registers.

A transfer opens with a start event. The first byte that follows carries the 7-bit word address and then a direction bit, so no separate device-select byte is used. In the write direction, data bytes collect in a four-byte page buffer. The stop that closes the transfer launches a self-timed commit phase, and the length of that phase is a parameter counted in system clocks. In the read direction, bytes stream out of the array for as long as the master acknowledges each one. The block only ever pulls the data line low, through an active-low enable.

Top module: `twowire_mem_slave`

## Requirements
- R1: While reset is asserted and after it is released, `sda_oe_n` is 1, so the data line is released.
- R2: Bit clocking that is not preceded by a start event, where a start is data falling while the clock is high, draws no acknowledge and leaves the line released.
- R3: The first byte after a start holds the word address, most significant bit first, followed by a direction bit in which 1 means read. When the block is not busy, it acknowledges this byte by driving `sda_oe_n` low for the ninth clock. `sda_oe_n` changes only after a clock falling edge, a start or a stop.
- R4: In the write direction, every complete data byte is acknowledged on its ninth clock.
- R5: In the read direction, the byte at the current address goes out most significant bit first, and a 0 bit is sent by driving `sda_oe_n` low. The line is released for the ninth clock. If the master drives the line low on that clock, the next byte follows from the address plus one.
- R6: Written bytes are buffered. The low two address bits advance and wrap inside the four-byte page, and nothing reaches the array until the stop that ends the write.
- R7: After a stop that ends a write holding at least one byte, the block is busy for `WRITE_CYCLES` system clocks. An address byte that arrives while the block is busy is not acknowledged. An address byte that arrives after the busy phase is acknowledged.
- R8: In the read direction, the address wraps from 127 to 0.
- R9: If the master does not acknowledge a read byte, the block keeps the line released until the next start or stop. A stop always releases the line and returns the block to idle.
- R10: A start at any point aborts the current transfer and discards uncommitted page data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad (wired-AND value) |
| sda_oe_n | output | 1 | Active-low pull-down enable for the data line; 0 drives the line low |

## Verification
The hardest situations to reach are the busy window and the wrap of a partial page. In the busy case, an address byte has to land while the commit counter is still running. The bench reaches it by issuing a fresh start right after the stop that ends a four-byte write. It uses a reduced `WRITE_CYCLES`, so the nine-bit address byte completes well inside the window. For the page wrap, the write begins at offset 2 of a page. The bench then reads the page back from its base address, which shows where the bytes landed after wrapping.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDAT,
    ST_WACK,
    ST_RDAT,
    ST_RACK,
    ST_HOLD
  } tw_state_e;
endpackage

// File: rtl/tw_bus_sense.sv
module tw_bus_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_lvl,
  output logic scl_up,
  output logic scl_dn,
  output logic start_ev,
  output logic stop_ev
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;
  logic scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_in};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_in};
      scl_q  <= scl_ff[SYNC_STAGES-1];
      sda_q  <= sda_ff[SYNC_STAGES-1];
    end
  end

  assign scl_s    = scl_ff[SYNC_STAGES-1];
  assign sda_lvl  = sda_ff[SYNC_STAGES-1];
  assign scl_up   = scl_s & ~scl_q;
  assign scl_dn   = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_lvl;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/tw_page_buf.sv
module tw_page_buf #(
  parameter int PAGE_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr,
  input  logic [PAGE_W-1:0] wslot,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PAGE_W-1:0] rslot,
  output logic [DATA_W-1:0] rdata,
  output logic [(1<<PAGE_W)-1:0] valid
);
  localparam int PAGE_N = 1 << PAGE_W;
  logic [DATA_W-1:0] slots [PAGE_N];

  always_ff @(posedge clk) begin
    if (rst || clr) valid <= '0;
    else if (wr) valid[wslot] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr) slots[wslot] <= wdata;
  end

  assign rdata = slots[rslot];
endmodule

// File: rtl/tw_mem_array.sv
module tw_mem_array #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/twowire_mem_slave.sv
module twowire_mem_slave #(
  parameter int ADDR_W       = 7,
  parameter int DATA_W       = 8,
  parameter int PAGE_W       = 2,
  parameter int WRITE_CYCLES = 1000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_oe_n
);
  import tw_pkg::*;

  localparam int PAGE_N = 1 << PAGE_W;
  localparam int CNT_W  = $clog2(WRITE_CYCLES);
  localparam int BIT_W  = $clog2(DATA_W + 1);

  logic sda_lvl, scl_up, scl_dn, start_ev, stop_ev;
  tw_state_e state;
  logic [BIT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] sh;
  logic [ADDR_W-1:0] addr;
  logic rw, ackd, busy;
  logic [CNT_W-1:0] bcnt;

  logic [DATA_W-1:0] mem_rdata, pb_rdata;
  logic [PAGE_N-1:0] pb_valid;
  logic [PAGE_W-1:0] cslot;
  logic byte_full, wr_byte, commit_we, busy_end, pb_clr;

  tw_bus_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .sda_lvl(sda_lvl), .scl_up(scl_up), .scl_dn(scl_dn),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  assign byte_full = (bit_cnt == BIT_W'(DATA_W));
  assign wr_byte   = (state == ST_WDAT) && scl_dn && byte_full && !start_ev && !stop_ev;
  assign cslot     = bcnt[PAGE_W-1:0];
  assign commit_we = busy && (bcnt < CNT_W'(PAGE_N)) && pb_valid[cslot];
  assign busy_end  = busy && (bcnt == CNT_W'(WRITE_CYCLES - 1));
  assign pb_clr    = (start_ev && !busy) || busy_end;

  tw_page_buf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_page (
    .clk(clk), .rst(rst), .clr(pb_clr), .wr(wr_byte),
    .wslot(addr[PAGE_W-1:0]), .wdata(sh),
    .rslot(cslot), .rdata(pb_rdata), .valid(pb_valid)
  );

  tw_mem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .we(commit_we),
    .waddr({addr[ADDR_W-1:PAGE_W], cslot}), .wdata(pb_rdata),
    .raddr(addr), .rdata(mem_rdata)
  );

  // self-timed commit counter
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      bcnt <= '0;
    end else if (busy) begin
      bcnt <= bcnt + CNT_W'(1);
      if (busy_end) busy <= 1'b0;
    end else if (stop_ev && (state == ST_WDAT || state == ST_WACK) && (|pb_valid)) begin
      busy <= 1'b1;
      bcnt <= '0;
    end
  end

  // bus protocol sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      sh       <= '0;
      addr     <= '0;
      rw       <= 1'b0;
      ackd     <= 1'b0;
      sda_oe_n <= 1'b1;
    end else if (start_ev) begin
      state    <= ST_ADDR;
      bit_cnt  <= '0;
      sda_oe_n <= 1'b1;
    end else if (stop_ev) begin
      state    <= ST_IDLE;
      sda_oe_n <= 1'b1;
    end else begin
      case (state)
        ST_ADDR, ST_WDAT: begin
          if (scl_up && !byte_full) begin
            sh      <= {sh[DATA_W-2:0], sda_lvl};
            bit_cnt <= bit_cnt + BIT_W'(1);
          end else if (scl_dn && byte_full) begin
            if (state == ST_ADDR) begin
              if (busy) state <= ST_HOLD;
              else begin
                addr     <= sh[DATA_W-1:1];
                rw       <= sh[0];
                sda_oe_n <= 1'b0;
                state    <= ST_AACK;
              end
            end else begin
              addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + PAGE_W'(1);
              sda_oe_n <= 1'b0;
              state    <= ST_WACK;
            end
          end
        end
        ST_AACK, ST_WACK: begin
          if (scl_dn) begin
            if (state == ST_AACK && rw) begin
              sda_oe_n <= mem_rdata[DATA_W-1];
              sh       <= {mem_rdata[DATA_W-2:0], 1'b0};
              bit_cnt  <= BIT_W'(1);
              state    <= ST_RDAT;
            end else begin
              sda_oe_n <= 1'b1;
              bit_cnt  <= '0;
              state    <= ST_WDAT;
            end
          end
        end
        ST_RDAT: begin
          if (scl_dn) begin
            if (byte_full) begin
              sda_oe_n <= 1'b1;
              addr     <= addr + ADDR_W'(1);
              state    <= ST_RACK;
            end else begin
              sda_oe_n <= sh[DATA_W-1];
              sh       <= {sh[DATA_W-2:0], 1'b0};
              bit_cnt  <= bit_cnt + BIT_W'(1);
            end
          end
        end
        ST_RACK: begin
          if (scl_up) ackd <= ~sda_lvl;
          else if (scl_dn) begin
            if (ackd) begin
              sda_oe_n <= mem_rdata[DATA_W-1];
              sh       <= {mem_rdata[DATA_W-2:0], 1'b0};
              bit_cnt  <= BIT_W'(1);
              state    <= ST_RDAT;
            end else begin
              state <= ST_HOLD;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tw_mem_slave_chk.sv
module tw_mem_slave_chk #(
  parameter int WRITE_CYCLES = 1000,
  parameter int CNT_W        = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             scl_dn,
  input logic             start_ev,
  input logic             stop_ev,
  input logic             sda_oe_n,
  input logic             busy,
  input tw_pkg::tw_state_e state,
  input logic [CNT_W-1:0] bcnt
);
  import tw_pkg::*;

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> sda_oe_n);

  p_oe_on_edge_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe_n) |-> $past(scl_dn || start_ev || stop_ev));

  p_busy_no_ack_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && state == ST_ADDR) |=> (state != ST_AACK));

  p_busy_len_r7: assert property (@(posedge clk) disable iff (rst)
    busy |-> (int'(bcnt) < WRITE_CYCLES));

  p_stop_release_r9: assert property (@(posedge clk) disable iff (rst)
    stop_ev |=> sda_oe_n);
endmodule

bind twowire_mem_slave tw_mem_slave_chk #(.WRITE_CYCLES(WRITE_CYCLES), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .scl_dn(scl_dn), .start_ev(start_ev), .stop_ev(stop_ev),
  .sda_oe_n(sda_oe_n), .busy(busy), .state(state), .bcnt(bcnt)
);

// File: tb/tb_twowire_mem_slave.sv
module tb_twowire_mem_slave;
  localparam int Q  = 4;
  localparam int WC = 300;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe_n;
  wire  line = sda_m & sda_oe_n;

  int vec = 0;
  int bad = 0;
  logic [7:0] mdl [128];

  always #2 clk = ~clk;

  twowire_mem_slave #(.WRITE_CYCLES(WC)) dut (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(line), .sda_oe_n(sda_oe_n)
  );

  task automatic check(input string req, input int got, input int exp);
    vec++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b0; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    scl_m = 1'b0; sda_m = 1'b0; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b1; qwait();
  endtask

  task automatic clock_bit(input logic b, output logic seen);
    sda_m = b; qwait();
    scl_m = 1'b1; qwait();
    seen = line; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
    clock_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, s);
      b[i] = s;
    end
    clock_bit(~mack, s);
  endtask

  task automatic mdl_page(input int base, input logic [7:0] d [$]);
    for (int i = 0; i < d.size(); i++)
      mdl[(base & 8'h7C) | ((base + i) & 3)] = d[i];
  endtask

  task automatic write_seq(input int a, input logic [7:0] d [$], input string req);
    logic ack;
    bus_start();
    send_byte({a[6:0], 1'b0}, ack);
    check({req, " addr ack"}, int'(ack), 1);
    foreach (d[i]) begin
      send_byte(d[i], ack);
      check("R4 data ack", int'(ack), 1);
    end
    bus_stop();
    mdl_page(a, d);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin : main
    logic ack;
    logic [7:0] b;
    repeat (5) @(negedge clk);
    check("R1 reset release", int'(sda_oe_n), 1);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check("R1 after reset", int'(sda_oe_n), 1);

    // R2: clocking without a start
    scl_m = 1'b0; qwait();
    send_byte(8'h0A, ack);
    check("R2 no start no ack", int'(ack), 0);
    bus_stop();

    // R3/R4/R5: single byte write, then read back
    write_seq(5, '{8'h3C}, "R3");
    repeat (WC + 50) @(negedge clk);
    bus_start();
    send_byte({7'd5, 1'b1}, ack);
    check("R3 read addr ack", int'(ack), 1);
    recv_byte(1'b0, b);
    check("R5 read byte", int'(b), int'(mdl[5]));
    bus_stop();

    // R6: page write starting at offset 2 wraps in page; R7 busy nack
    write_seq(8'h12, '{8'hA1, 8'hB2, 8'hC3, 8'hD4}, "R6");
    bus_start();
    send_byte({7'h12, 1'b1}, ack);
    check("R7 busy no ack", int'(ack), 0);
    bus_stop();
    repeat (WC + 50) @(negedge clk);
    bus_start();
    send_byte({7'h10, 1'b1}, ack);
    check("R7 ack after busy", int'(ack), 1);
    for (int i = 0; i < 4; i++) begin
      recv_byte(i != 3, b);
      check("R6 page wrap readback", int'(b), int'(mdl[8'h10 + i]));
    end
    bus_stop();
    check("R6 wrapped slot", int'(mdl[8'h10]), 8'hC3);

    // R8: read address wrap 127 -> 0
    write_seq(8'h7F, '{8'h5A}, "R8");
    repeat (WC + 50) @(negedge clk);
    write_seq(8'h00, '{8'h6B}, "R8");
    repeat (WC + 50) @(negedge clk);
    bus_start();
    send_byte({7'h7F, 1'b1}, ack);
    check("R8 addr ack", int'(ack), 1);
    recv_byte(1'b1, b);
    check("R8 byte at 127", int'(b), int'(mdl[127]));
    recv_byte(1'b0, b);
    check("R8 wrapped byte at 0", int'(b), int'(mdl[0]));
    bus_stop();

    // R9: master nack silences the block until stop
    bus_start();
    send_byte({7'h10, 1'b1}, ack);
    recv_byte(1'b0, b);
    check("R9 byte before nack", int'(b), int'(mdl[8'h10]));
    recv_byte(1'b0, b);
    check("R9 silent after nack", int'(b), 8'hFF);
    bus_stop();
    check("R9 released after stop", int'(sda_oe_n), 1);
    bus_start();
    send_byte({7'h11, 1'b1}, ack);
    check("R9 ack after stop", int'(ack), 1);
    recv_byte(1'b0, b);
    check("R9 new read", int'(b), int'(mdl[8'h11]));
    bus_stop();

    // R10: repeated start discards uncommitted page data
    write_seq(8'h20, '{8'h11}, "R10");
    repeat (WC + 50) @(negedge clk);
    bus_start();
    send_byte({7'h20, 1'b0}, ack);
    send_byte(8'hEE, ack);
    check("R10 data ack", int'(ack), 1);
    bus_start();
    send_byte({7'h20, 1'b1}, ack);
    check("R10 not busy after abort", int'(ack), 1);
    recv_byte(1'b0, b);
    check("R10 old value kept", int'(b), int'(mdl[8'h20]));
    bus_stop();

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule